// File: doc/BRIEF.md
# Security-Tagged Ownership Lock for a Shared Accelerator

This block sits between a register bus and a shared accelerator. It decides which security world, secure or non-secure, may use the accelerator. Software takes the lock by reading a lock register. If that read returns zero, the caller now owns the accelerator. The block records the owning world as a 2-bit code. It then forwards accelerator register accesses only from that world. Every other accelerator access is refused with an error response.

The owner gives up the lock by writing zero to the lock register. The secure world has one more option: it can reclaim an accelerator held by the non-secure world by writing to a secure-only preemption register. Every release, normal or forced, raises a one-cycle clear pulse toward the accelerator. This wipes the accelerator's state before the next owner can see it.

The bus side accepts one access per cycle. Each access carries a read/write flag, a secure attribute, an address and write data. Every access is answered one cycle later. Accelerator accesses that are allowed are passed straight through in the same cycle. The accelerator returns its read data combinationally in that cycle.

Top module: `sec_mutex_gate`

## Requirements
- R1: After reset the lock is free (owner code 2'b00), no response is pending (rsp_valid=0) and eng_clear is low.
- R2: A read of the lock register (offset 0x00) while the lock is free returns 0 with no error. The owner code becomes 2'b01 for a secure read and 2'b10 for a non-secure read.
- R3: A read of the lock register while the lock is held returns the current owner code in bits [1:0], with no error, from either world. Ownership does not change.
- R4: A write of zero to the lock register from the owning world releases the lock. A write of a nonzero value, or a write from the other world, is ignored and answered without error.
- R5: An access to any offset other than 0x00 and 0x04 is forwarded to the accelerator (eng_req_valid=1) only when the caller's world owns the lock. Otherwise it is not forwarded and completes with rsp_err=1.
- R6: A secure write with bit 0 set to the preemption register (offset 0x04) force-releases the lock when the non-secure world holds it. The same write has no effect when the lock is free or held by the secure world, and a secure write with bit 0 clear has no effect.
- R7: Any non-secure access to the preemption register completes with rsp_err=1 and leaves ownership unchanged.
- R8: eng_clear is high for exactly the one cycle after each release, whether normal or forced, and is low otherwise.
- R9: Every access is answered with rsp_valid=1 in the following cycle. A response with rsp_err=1 carries rsp_rdata=0, and accelerator read data is returned for allowed accelerator reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure-world access |
| req_addr | input | ADDR_W | Register offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | DATA_W | Read data (zero on error or write) |
| eng_req_valid | output | 1 | Allowed access forwarded to the accelerator |
| eng_req_write | output | 1 | Forwarded write flag |
| eng_req_addr | output | ADDR_W | Forwarded offset |
| eng_req_wdata | output | DATA_W | Forwarded write data |
| eng_rdata | input | DATA_W | Accelerator read data, valid in the forwarding cycle |
| eng_clear | output | 1 | One-cycle wipe of accelerator state after a release |

## Verification
The hardest situation to reach is a forced release. It needs the non-secure world to own the lock and then a secure write to the preemption register. Before that write, the bench must prove that the secure world cannot get in any other way. So the stimulus first takes the lock as non-secure. It then tries secure accelerator accesses, a secure release write and a preemption write with bit 0 clear, and confirms that all of them fail. Only then does it issue the real preemption and check the clear pulse and the freed lock. A non-secure preemption attempt while the secure world owns the lock covers the reverse direction.

// File: rtl/mutex_pkg.sv
// Shared types for the security-tagged ownership lock.
// Assumes a 2-bit owner code, with one bit per world at most set.
package mutex_pkg;

    typedef enum logic [1:0] {
        OWN_FREE = 2'b00,
        OWN_SEC  = 2'b01,
        OWN_NSEC = 2'b10
    } owner_e;

    typedef enum logic [1:0] {
        TGT_LOCK    = 2'b00,
        TGT_PREEMPT = 2'b01,
        TGT_ENGINE  = 2'b10
    } target_e;

    // Map a secure attribute to the owner code that world would hold.
    function automatic owner_e world_code(input logic secure);
        return secure ? OWN_SEC : OWN_NSEC;
    endfunction

endpackage

// File: rtl/mutex_addr_decode.sv
// Classifies a bus offset as lock register, preemption register or
// accelerator space. Purely combinational; assumes exact-match offsets.
module mutex_addr_decode
    import mutex_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LOCK_OFF    = 'h00,
    parameter int PREEMPT_OFF = 'h04
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           tgt
);

    localparam logic [ADDR_W-1:0] LockA    = ADDR_W'(LOCK_OFF);
    localparam logic [ADDR_W-1:0] PreemptA = ADDR_W'(PREEMPT_OFF);

    // Pick the target from the offset.
    always_comb begin
        if (addr == LockA)         tgt = TGT_LOCK;
        else if (addr == PreemptA) tgt = TGT_PREEMPT;
        else                       tgt = TGT_ENGINE;
    end

endmodule

// File: rtl/mutex_access_gate.sv
// Turns one decoded bus access plus the current owner into lock events
// (acquire, release, forced release), a forward enable and an error flag.
// Assumes at most one access per cycle and an owner that is never 2'b11.
module mutex_access_gate
    import mutex_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  target_e           tgt,
    input  logic [DATA_W-1:0] req_wdata,
    input  owner_e            owner,
    output logic              acq,
    output logic              rel,
    output logic              force_rel,
    output logic              fwd,
    output logic              err
);

    logic own_match;
    logic is_lock;
    logic is_pre;
    logic is_eng;

    // Does the caller's world match the recorded owner?
    always_comb own_match = (owner != OWN_FREE) && (owner == world_code(req_secure));

    // Target strobes, qualified by a valid access.
    always_comb begin
        is_lock = req_valid && (tgt == TGT_LOCK);
        is_pre  = req_valid && (tgt == TGT_PREEMPT);
        is_eng  = req_valid && (tgt == TGT_ENGINE);
    end

    // Lock events derived from the access.
    always_comb begin
        acq       = is_lock && !req_write && (owner == OWN_FREE);
        rel       = is_lock && req_write && (req_wdata == '0) && own_match;
        force_rel = is_pre && req_write && req_secure && req_wdata[0] && (owner == OWN_NSEC);
    end

    // Forwarding and refusal.
    always_comb begin
        fwd = is_eng && own_match;
        err = (is_eng && !own_match) || (is_pre && !req_secure);
    end

endmodule

// File: rtl/mutex_owner_track.sv
// Holds the owner code and produces the one-cycle clear pulse after any
// release. Assumes the gate never raises acquire and release together.
module mutex_owner_track
    import mutex_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   acq,
    input  logic   acq_secure,
    input  logic   rel,
    input  logic   force_rel,
    output owner_e owner,
    output logic   clear_pulse
);

    // Owner register: set on acquire, freed on any release.
    always_ff @(posedge clk) begin
        if (!rst_n)                owner <= OWN_FREE;
        else if (acq)              owner <= world_code(acq_secure);
        else if (rel || force_rel) owner <= OWN_FREE;
    end

    // Clear pulse follows every release by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) clear_pulse <= 1'b0;
        else        clear_pulse <= rel || force_rel;
    end

endmodule

// File: rtl/sec_mutex_gate.sv
// Top of the security-tagged ownership lock. Decodes each bus access,
// gates accelerator accesses on ownership, and registers a response one
// cycle later. Assumes the accelerator returns read data combinationally.
module sec_mutex_gate
    import mutex_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int LOCK_OFF    = 'h00,
    parameter int PREEMPT_OFF = 'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              eng_req_valid,
    output logic              eng_req_write,
    output logic [ADDR_W-1:0] eng_req_addr,
    output logic [DATA_W-1:0] eng_req_wdata,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              eng_clear
);

    localparam int PadW = DATA_W - 2;

    target_e           tgt;
    owner_e            owner_q;
    logic              acq;
    logic              rel;
    logic              force_rel;
    logic              fwd;
    logic              err;
    logic [DATA_W-1:0] rdata_d;

    mutex_addr_decode #(
        .ADDR_W     (ADDR_W),
        .LOCK_OFF   (LOCK_OFF),
        .PREEMPT_OFF(PREEMPT_OFF)
    ) u_dec (
        .addr(req_addr),
        .tgt (tgt)
    );

    mutex_access_gate #(
        .DATA_W(DATA_W)
    ) u_gate (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_secure(req_secure),
        .tgt       (tgt),
        .req_wdata (req_wdata),
        .owner     (owner_q),
        .acq       (acq),
        .rel       (rel),
        .force_rel (force_rel),
        .fwd       (fwd),
        .err       (err)
    );

    mutex_owner_track u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq        (acq),
        .acq_secure (req_secure),
        .rel        (rel),
        .force_rel  (force_rel),
        .owner      (owner_q),
        .clear_pulse(eng_clear)
    );

    // Pass allowed accelerator accesses straight through.
    always_comb begin
        eng_req_valid = fwd;
        eng_req_write = req_write;
        eng_req_addr  = req_addr;
        eng_req_wdata = req_wdata;
    end

    // Select read data: zero on error or write, owner code for lock reads.
    always_comb begin
        rdata_d = '0;
        if (req_valid && !req_write && !err) begin
            if (tgt == TGT_LOCK)        rdata_d = {{PadW{1'b0}}, owner_q};
            else if (tgt == TGT_ENGINE) rdata_d = eng_rdata;
        end
    end

    // Response register, one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && err;
            rsp_rdata <= rdata_d;
        end
    end

endmodule

// File: rtl/mutex_gate_chk.sv
// Property checker for sec_mutex_gate, bound to every instance.
module mutex_gate_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_secure,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              eng_req_valid,
    input logic              eng_clear,
    input logic [1:0]        owner
);

    // R2: the owner code never has both world bits set.
    p_owner_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        owner != 2'b11);

    // R5: a forwarded access always comes from the owning world.
    p_fwd_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid |-> (owner == (req_secure ? 2'b01 : 2'b10)));

    // R8: the clear pulse never lasts two cycles.
    p_clear_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_clear |=> !eng_clear);

    // R8: a held lock that becomes free is followed by a clear pulse.
    p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner != 2'b00) ##1 (owner == 2'b00)) |-> eng_clear);

    // R9: every access is answered in the next cycle.
    p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9: a refused access carries zero data.
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R4: a secure owner keeps the lock while only non-secure traffic arrives.
    p_ns_cannot_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'b01 && !(req_valid && req_secure)) |=> owner == 2'b01);

endmodule

bind sec_mutex_gate mutex_gate_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_secure   (req_secure),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .eng_req_valid(eng_req_valid),
    .eng_clear    (eng_clear),
    .owner        (owner_q)
);

// File: tb/test_sec_mutex_gate.sv
`timescale 1ns/1ps
module test_sec_mutex_gate;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_LOCK = 8'h00;
    localparam logic [AW-1:0] A_PRE  = 8'h04;
    localparam logic [AW-1:0] A_ENG  = 8'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_secure = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          eng_req_valid;
    logic          eng_req_write;
    logic [AW-1:0] eng_req_addr;
    logic [DW-1:0] eng_req_wdata;
    logic [DW-1:0] eng_rdata;
    logic          eng_clear;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] got_data;
    logic          got_err;
    logic          got_fwd;
    logic          got_clr;
    logic          got_vld;

    always #2 clk = ~clk;

    // Simple accelerator model: read data tagged with the offset.
    assign eng_rdata = 32'hA500_0000 | {24'h0, eng_req_addr};

    sec_mutex_gate i_sec_mutex_gate (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .eng_req_valid(eng_req_valid), .eng_req_write(eng_req_write),
        .eng_req_addr(eng_req_addr), .eng_req_wdata(eng_req_wdata),
        .eng_rdata(eng_rdata), .eng_clear(eng_clear)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus access: drive at negedge, sample the response after the edge.
    task automatic access(input logic wr, input logic sec, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec; req_addr = a; req_wdata = wd;
        #1 got_fwd = eng_req_valid;
        @(posedge clk);
        #1;
        got_vld = rsp_valid; got_err = rsp_err; got_data = rsp_rdata; got_clr = eng_clear;
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 rsp_valid", {31'b0, got_vld}, 32'd1);
    endtask

    // Idle cycle: no response and no clear pulse expected.
    task automatic idle_quiet(input string req);
        @(posedge clk);
        #1;
        check({req, " clear low"}, {31'b0, eng_clear}, 32'd0);
        check("R9 no rsp when idle", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R1 eng_clear", {31'b0, eng_clear}, 32'd0);
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R1 free after reset", got_data, 32'd0);
    endtask

    // Secure owner: blocking, ignored writes, normal release.
    task automatic t_secure_owner();
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R3 secure reread", got_data, 32'd1);
        check("R3 no err", {31'b0, got_err}, 32'd0);
        access(1'b0, 1'b0, A_LOCK, '0);
        check("R3 ns sees owner", got_data, 32'd1);
        access(1'b0, 1'b0, A_ENG, '0);
        check("R5 ns blocked err", {31'b0, got_err}, 32'd1);
        check("R5 ns blocked data", got_data, 32'd0);
        check("R5 ns not fwd", {31'b0, got_fwd}, 32'd0);
        access(1'b0, 1'b1, A_ENG, '0);
        check("R5 sec fwd", {31'b0, got_fwd}, 32'd1);
        check("R9 eng data", got_data, 32'hA500_0020);
        access(1'b1, 1'b0, A_LOCK, '0);
        check("R4 ns release no err", {31'b0, got_err}, 32'd0);
        check("R4 ns release no clear", {31'b0, got_clr}, 32'd0);
        access(1'b1, 1'b0, A_PRE, 32'd1);
        check("R7 ns preempt err", {31'b0, got_err}, 32'd1);
        access(1'b1, 1'b1, A_PRE, 32'd1);
        check("R6 preempt on secure no clear", {31'b0, got_clr}, 32'd0);
        access(1'b1, 1'b1, A_LOCK, 32'd5);
        check("R4 nonzero write no clear", {31'b0, got_clr}, 32'd0);
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R4 still secure owned", got_data, 32'd1);
        access(1'b1, 1'b1, A_LOCK, '0);
        check("R8 clear after release", {31'b0, got_clr}, 32'd1);
        idle_quiet("R8");
        access(1'b0, 1'b0, A_LOCK, '0);
        check("R2 ns acquire returns 0", got_data, 32'd0);
        access(1'b0, 1'b0, A_LOCK, '0);
        check("R2 ns code", got_data, 32'd2);
    endtask

    // Non-secure owner: secure locked out until a forced release.
    task automatic t_preempt();
        access(1'b1, 1'b0, A_ENG, 32'h1234);
        check("R5 ns write fwd", {31'b0, got_fwd}, 32'd1);
        check("R5 ns write ok", {31'b0, got_err}, 32'd0);
        access(1'b0, 1'b1, A_ENG, '0);
        check("R5 sec blocked", {31'b0, got_err}, 32'd1);
        check("R5 sec not fwd", {31'b0, got_fwd}, 32'd0);
        access(1'b1, 1'b1, A_LOCK, '0);
        check("R4 sec release ignored", {31'b0, got_clr}, 32'd0);
        access(1'b1, 1'b1, A_PRE, 32'd0);
        check("R6 bit0 clear no effect", {31'b0, got_clr}, 32'd0);
        access(1'b0, 1'b0, A_PRE, '0);
        check("R7 ns preempt read err", {31'b0, got_err}, 32'd1);
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R6 still ns owned", got_data, 32'd2);
        access(1'b1, 1'b1, A_PRE, 32'd1);
        check("R6 preempt ok", {31'b0, got_err}, 32'd0);
        check("R8 clear after preempt", {31'b0, got_clr}, 32'd1);
        idle_quiet("R8");
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R6 freed, sec acquires", got_data, 32'd0);
        access(1'b1, 1'b1, A_PRE, 32'd1);
        check("R6 preempt on free/secure no clear", {31'b0, got_clr}, 32'd0);
        access(1'b0, 1'b1, A_LOCK, '0);
        check("R6 sec keeps lock", got_data, 32'd1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_secure_owner();
        t_preempt();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule